// File: doc/BRIEF.md
# Memory Region Permission Checker

This block decides whether a single memory access may proceed. It takes the access start address, the byte count, the requested read/write/execute mask and the privilege mode. It compares them against a set of region entries that are already decoded into inclusive lower and upper byte bounds, each with its own configuration bits. Entries are scanned from index 0 upward, and the first active entry that the access touches decides the outcome.

Two rule sets are available. The classic rule hands the entry's own permission bits to lower privilege modes. It lets machine mode through unless the entry is locked. When the lockdown control is set, a 16-way table indexed by the entry's lock/read/write/execute bits is used instead, with one column for machine mode and one for the lower modes. When no entry is touched, a default policy applies that depends on the strict-deny and lockdown controls.

The verdict and the allowed mask come out registered, one cycle after the request strobe. The register file, bound decoding and any translation caching sit outside the block.

Top module: `pmp_access_check`

## Requirements
- R1: `rsp_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. Reset drives `rsp_valid_o`, `rsp_grant_o` and `rsp_perm_o` to 0.
- R2: Each entry's 5-bit configuration is laid out as bit 4 active, bit 3 lock (L), bit 2 read (R), bit 1 write (W) and bit 0 execute (X). An entry's region is the inclusive range lo..hi. Inactive entries are ignored. The lowest-numbered active entry containing the first or the last byte decides the result, with no fallback to later entries or to the default policy.
- R3: The last byte is address + size − 1. A size of 0 stands for one machine word of WORD_BYTES bytes (default 4).
- R4: If exactly one of the first and last byte lies inside the deciding entry, the access is denied and the allowed mask is 0.
- R5: With lockdown off, a fully contained access in a lower mode gets the entry's R/W/X bits. Machine mode (`req_mode_i` = 3) gets RWX, or the entry's bits when L is set.
- R6: With lockdown on in machine mode, the table index is {L,R,W,X}. Indices 2, 3 and 14 give RW; 12 and 15 give R; 9 and 10 give X; 11 and 13 give RX; every other index gives nothing.
- R7: With lockdown on in lower modes, indices 3 and 6 give RW; 7 gives RWX; 5 gives RX; 2, 4 and 15 give R; 1, 10 and 11 give X; every other index gives nothing.
- R8: When no active entry is touched and strict-deny (`mmwp_i`) is set, the mask is 0 and the access is denied.
- R9: When no active entry is touched, strict-deny is clear and lockdown is set, a machine-mode access that does not request X is granted with mask RW. Any other access is denied with mask 0.
- R10: When no active entry is touched and both controls are clear, machine mode is granted with mask RWX. Lower modes are denied with mask 0.
- R11: When an entry decides without partial overlap, the grant is high exactly when every requested bit is present in the allowed mask. The mask encoding is bit 2 R, bit 1 W, bit 0 X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | AW | First byte address |
| req_size_i | input | SW | Byte count, 0 means one word |
| req_perm_i | input | 3 | Requested R/W/X mask |
| req_mode_i | input | 2 | Privilege mode, 3 is machine |
| mml_i | input | 1 | Lockdown rule select |
| mmwp_i | input | 1 | Strict default deny |
| ent_lo_i | input | N*AW | Entry lower bounds, entry i at bits i*AW |
| ent_hi_i | input | N*AW | Entry upper bounds (inclusive) |
| ent_cfg_i | input | N*5 | Entry configuration, entry i at bits i*5 |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_grant_o | output | 1 | Access allowed |
| rsp_perm_o | output | 3 | Allowed R/W/X mask |

## Verification
The embedded assertions watch the response timing, the selector, and the grant/mask relation on every cycle. The selector must name at most one entry. A grant must never carry a requested bit missing from the mask. A partial overlap or an untouched access under strict-deny must always produce a zero mask. Only the bench scenarios can show the priority order among overlapping entries, the word-sized reading of a zero size, the locked-entry behaviour in machine mode, and every cell of both lockdown tables, because these depend on the programmed entry contents.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  localparam int CFG_W   = 5;
  localparam int CFG_ACT = 4;
  localparam int CFG_LCK = 3;
  localparam int PERM_W  = 3;
  localparam logic [1:0] MODE_MACHINE = 2'b11;

  localparam logic [2:0] P_NONE = 3'b000;
  localparam logic [2:0] P_R    = 3'b100;
  localparam logic [2:0] P_RW   = 3'b110;
  localparam logic [2:0] P_X    = 3'b001;
  localparam logic [2:0] P_RX   = 3'b101;
  localparam logic [2:0] P_RWX  = 3'b111;

  typedef struct packed {
    logic       ok;
    logic [2:0] perm;
  } verdict_t;

  // lockdown table, machine column
  function automatic logic [2:0] lock_tbl_machine(input logic [3:0] k);
    case (k)
      4'd2, 4'd3, 4'd14:  return P_RW;
      4'd9, 4'd10:        return P_X;
      4'd11, 4'd13:       return P_RX;
      4'd12, 4'd15:       return P_R;
      default:            return P_NONE;
    endcase
  endfunction

  // lockdown table, lower-mode column
  function automatic logic [2:0] lock_tbl_lower(input logic [3:0] k);
    case (k)
      4'd1, 4'd10, 4'd11: return P_X;
      4'd2, 4'd4, 4'd15:  return P_R;
      4'd3, 4'd6:         return P_RW;
      4'd5:               return P_RX;
      4'd7:               return P_RWX;
      default:            return P_NONE;
    endcase
  endfunction

  function automatic logic [2:0] classic_perm(input logic [3:0] lrwx, input logic is_m);
    if (is_m && !lrwx[3]) return P_RWX;
    return lrwx[2:0];
  endfunction

  function automatic verdict_t fallback_verdict(input logic mml, input logic mmwp,
                                                input logic is_m, input logic want_x);
    verdict_t v;
    if (mmwp) begin
      v = '{ok: 1'b0, perm: P_NONE};
    end else if (mml) begin
      if (is_m && !want_x) v = '{ok: 1'b1, perm: P_RW};
      else                 v = '{ok: 1'b0, perm: P_NONE};
    end else if (is_m) begin
      v = '{ok: 1'b1, perm: P_RWX};
    end else begin
      v = '{ok: 1'b0, perm: P_NONE};
    end
    return v;
  endfunction

  function automatic logic perm_covers(input logic [2:0] want, input logic [2:0] have);
    return (want & ~have) == 3'b000;
  endfunction

endpackage

// File: rtl/pmp_range_probe.sv
module pmp_range_probe #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic          active_i,
  input  logic [AW-1:0] first_i,
  input  logic [AW-1:0] last_i,
  output logic          first_in_o,
  output logic          last_in_o
);
  assign first_in_o = active_i && (first_i >= lo_i) && (first_i <= hi_i);
  assign last_in_o  = active_i && (last_i  >= lo_i) && (last_i  <= hi_i);
endmodule

// File: rtl/pmp_prio_pick.sv
module pmp_prio_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  touch_i,
  output logic [N-1:0]  sel_onehot_o,
  output logic [IW-1:0] sel_idx_o,
  output logic          hit_o
);
  always_comb begin
    logic found;
    found        = 1'b0;
    sel_onehot_o = '0;
    sel_idx_o    = '0;
    for (int i = 0; i < N; i++) begin
      if (touch_i[i] && !found) begin
        found           = 1'b1;
        sel_onehot_o[i] = 1'b1;
        sel_idx_o       = IW'(i);
      end
    end
    hit_o = found;
  end

  // R2
  sel_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_onehot_o) && (hit_o == (touch_i != '0)));
endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
  import pmp_chk_pkg::*;
(
  input  logic       hit_i,
  input  logic       partial_i,
  input  logic [3:0] lrwx_i,
  input  logic       mml_i,
  input  logic       mmwp_i,
  input  logic [1:0] mode_i,
  input  logic [2:0] want_i,
  output logic [2:0] perm_o,
  output logic       grant_o
);
  logic     is_m;
  verdict_t dflt;
  logic [2:0] rule_perm;

  assign is_m = (mode_i == MODE_MACHINE);
  assign dflt = fallback_verdict(mml_i, mmwp_i, is_m, want_i[0]);

  always_comb begin
    if (!mml_i)    rule_perm = classic_perm(lrwx_i, is_m);
    else if (is_m) rule_perm = lock_tbl_machine(lrwx_i);
    else           rule_perm = lock_tbl_lower(lrwx_i);
  end

  always_comb begin
    if (!hit_i) begin
      perm_o  = dflt.perm;
      grant_o = dflt.ok;
    end else if (partial_i) begin
      perm_o  = P_NONE;
      grant_o = 1'b0;
    end else begin
      perm_o  = rule_perm;
      grant_o = perm_covers(want_i, rule_perm);
    end
  end
endmodule

// File: rtl/pmp_access_check.sv
module pmp_access_check
  import pmp_chk_pkg::*;
#(
  parameter int N          = 8,
  parameter int AW         = 32,
  parameter int SW         = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [SW-1:0]     req_size_i,
  input  logic [2:0]        req_perm_i,
  input  logic [1:0]        req_mode_i,
  input  logic              mml_i,
  input  logic              mmwp_i,
  input  logic [N*AW-1:0]   ent_lo_i,
  input  logic [N*AW-1:0]   ent_hi_i,
  input  logic [N*CFG_W-1:0] ent_cfg_i,
  output logic              rsp_valid_o,
  output logic              rsp_grant_o,
  output logic [2:0]        rsp_perm_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [AW-1:0]    span_len;
  logic [AW-1:0]    last_byte;
  logic [N-1:0]     first_in, last_in, touch, sel_onehot;
  logic [CFG_W-1:0] cfg_arr [N];
  logic [IW-1:0]    sel_idx;
  logic             any_hit;
  logic             straddle;
  logic [3:0]       sel_lrwx;
  logic [2:0]       comb_perm;
  logic             comb_grant;

  // R3: zero size means one word
  assign span_len  = (req_size_i == '0) ? AW'(WORD_BYTES) : AW'(req_size_i);
  assign last_byte = req_addr_i + span_len - AW'(1);

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign cfg_arr[g] = ent_cfg_i[g*CFG_W +: CFG_W];
    pmp_range_probe #(.AW(AW)) u_probe (
      .lo_i       (ent_lo_i[g*AW +: AW]),
      .hi_i       (ent_hi_i[g*AW +: AW]),
      .active_i   (cfg_arr[g][CFG_ACT]),
      .first_i    (req_addr_i),
      .last_i     (last_byte),
      .first_in_o (first_in[g]),
      .last_in_o  (last_in[g])
    );
    assign touch[g] = first_in[g] | last_in[g];
  end

  pmp_prio_pick #(.N(N)) u_pick (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_i      (touch),
    .sel_onehot_o (sel_onehot),
    .sel_idx_o    (sel_idx),
    .hit_o        (any_hit)
  );

  assign straddle = any_hit && (first_in[sel_idx] ^ last_in[sel_idx]);
  assign sel_lrwx = cfg_arr[sel_idx][3:0];

  pmp_perm_eval u_eval (
    .hit_i     (any_hit),
    .partial_i (straddle),
    .lrwx_i    (sel_lrwx),
    .mml_i     (mml_i),
    .mmwp_i    (mmwp_i),
    .mode_i    (req_mode_i),
    .want_i    (req_perm_i),
    .perm_o    (comb_perm),
    .grant_o   (comb_grant)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_grant_o <= 1'b0;
      rsp_perm_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_grant_o <= comb_grant;
        rsp_perm_o  <= comb_perm;
      end
    end
  end

  // R1
  resp_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R1
  resp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R11
  grant_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i ##1 rsp_grant_o |-> (($past(req_perm_i) & ~rsp_perm_o) == 3'b000));
  // R4
  straddle_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && straddle) |=> (!rsp_grant_o && rsp_perm_o == 3'b000));
  // R8
  strict_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !any_hit && mmwp_i) |=> (!rsp_grant_o && rsp_perm_o == 3'b000));
endmodule

// File: tb/pmp_access_check_bench.sv
`timescale 1ns/1ps
module pmp_access_check_bench;
  localparam int N = 8, AW = 32, SW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = '0;
  logic [2:0]    req_perm = '0;
  logic [1:0]    req_mode = '0;
  logic          mml = 1'b0, mmwp = 1'b0;
  logic [AW-1:0] lo [N];
  logic [AW-1:0] hi [N];
  logic [4:0]    cfg [N];
  logic [N*AW-1:0] lo_bus, hi_bus;
  logic [N*5-1:0]  cfg_bus;
  logic          rsp_valid, rsp_grant;
  logic [2:0]    rsp_perm;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      lo_bus[i*AW +: AW] = lo[i];
      hi_bus[i*AW +: AW] = hi[i];
      cfg_bus[i*5 +: 5]  = cfg[i];
    end
  end

  pmp_access_check u_pmp_access_check (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_perm_i(req_perm), .req_mode_i(req_mode),
    .mml_i(mml), .mmwp_i(mmwp), .ent_lo_i(lo_bus), .ent_hi_i(hi_bus),
    .ent_cfg_i(cfg_bus), .rsp_valid_o(rsp_valid), .rsp_grant_o(rsp_grant),
    .rsp_perm_o(rsp_perm));

  int checks = 0, errors = 0;

  typedef struct packed {
    logic        mml; logic mmwp; logic [1:0] mode;
    logic [11:0] addr; logic [3:0] size; logic [2:0] want;
    logic        eg; logic [2:0] ep;
  } vec_t;

  // fixed layout: e0 [0x100,0x10F] R; e1 [0x100,0x1FF] RWX; e2 [0x200,0x2FF] L+RX;
  // e3 [0x300,0x3FF] inactive RWX
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,2'd0,12'h104,4'd4,3'b100,1'b1,3'b100}, // R2 R5 user read on e0
    '{1'b0,1'b0,2'd0,12'h104,4'd4,3'b010,1'b0,3'b100}, // R11 write refused
    '{1'b0,1'b0,2'd0,12'h10C,4'd8,3'b100,1'b0,3'b000}, // R4 R2 straddle, no fallback to e1
    '{1'b0,1'b0,2'd0,12'h120,4'd4,3'b110,1'b1,3'b111}, // R2 next entry decides
    '{1'b0,1'b0,2'd3,12'h104,4'd4,3'b010,1'b1,3'b111}, // R5 machine unlocked
    '{1'b0,1'b0,2'd3,12'h210,4'd4,3'b010,1'b0,3'b101}, // R5 machine locked
    '{1'b0,1'b0,2'd1,12'h210,4'd4,3'b001,1'b1,3'b101}, // R5 lower on locked
    '{1'b0,1'b0,2'd0,12'h310,4'd4,3'b100,1'b0,3'b000}, // R10 R2 inactive skipped
    '{1'b0,1'b0,2'd3,12'h310,4'd4,3'b001,1'b1,3'b111}, // R10 machine default
    '{1'b0,1'b0,2'd0,12'h1FE,4'd0,3'b100,1'b0,3'b000}, // R3 zero size straddles
    '{1'b0,1'b0,2'd0,12'h1FC,4'd0,3'b100,1'b1,3'b111}, // R3 zero size fits
    '{1'b1,1'b0,2'd3,12'h310,4'd4,3'b110,1'b1,3'b110}, // R9 machine RW
    '{1'b1,1'b0,2'd3,12'h310,4'd4,3'b001,1'b0,3'b000}, // R9 machine exec refused
    '{1'b0,1'b1,2'd3,12'h310,4'd4,3'b100,1'b0,3'b000}, // R8 strict deny
    '{1'b0,1'b1,2'd3,12'h104,4'd4,3'b100,1'b1,3'b111}, // R8 only when untouched
    '{1'b0,1'b0,2'd0,12'h104,4'd4,3'b000,1'b1,3'b100}  // R11 empty request
  };

  localparam logic [2:0] TBL_M [16] = '{3'd0,3'd0,3'd6,3'd6,3'd0,3'd0,3'd0,3'd0,
                                        3'd0,3'd1,3'd1,3'd5,3'd4,3'd5,3'd6,3'd4};
  localparam logic [2:0] TBL_U [16] = '{3'd0,3'd1,3'd4,3'd6,3'd4,3'd5,3'd6,3'd7,
                                        3'd0,3'd0,3'd1,3'd1,3'd0,3'd0,3'd0,3'd4};

  task automatic check1(input string req, input string what, input logic [3:0] act,
                        input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic m_l, input logic m_w, input logic [1:0] md,
                       input logic [AW-1:0] a, input logic [SW-1:0] s, input logic [2:0] w,
                       input logic eg, input logic [2:0] ep, input string req);
    @(negedge clk);
    mml = m_l; mmwp = m_w; req_mode = md; req_addr = a; req_size = s; req_perm = w;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check1(req, "valid", {3'b0, rsp_valid}, 4'd1);
    check1(req, "grant", {3'b0, rsp_grant}, {3'b0, eg});
    check1(req, "perm",  {1'b0, rsp_perm},  {1'b0, ep});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin lo[i] = '1; hi[i] = '0; cfg[i] = '0; end
    lo[0] = 32'h100; hi[0] = 32'h10F; cfg[0] = 5'b10100;
    lo[1] = 32'h100; hi[1] = 32'h1FF; cfg[1] = 5'b10111;
    lo[2] = 32'h200; hi[2] = 32'h2FF; cfg[2] = 5'b11101;
    lo[3] = 32'h300; hi[3] = 32'h3FF; cfg[3] = 5'b00111;
    repeat (3) @(negedge clk);
    // R1 reset state
    check1("R1", "reset valid", {3'b0, rsp_valid}, 4'd0);
    check1("R1", "reset grant", {3'b0, rsp_grant}, 4'd0);
    check1("R1", "reset perm",  {1'b0, rsp_perm},  4'd0);
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      issue(VEC[v].mml, VEC[v].mmwp, VEC[v].mode, {20'd0, VEC[v].addr}, VEC[v].size,
            VEC[v].want, VEC[v].eg, VEC[v].ep, $sformatf("vec%0d", v));
    end
    @(negedge clk);
    check1("R1", "idle valid", {3'b0, rsp_valid}, 4'd0);
    // R6 R7 lockdown tables over every index, entry 0 reprogrammed
    for (int k = 0; k < 16; k++) begin
      cfg[0] = {1'b1, 4'(k)};
      issue(1'b1, 1'b0, 2'd3, 32'h104, 4'd4, 3'b100, TBL_M[k][2], TBL_M[k], "R6");
      issue(1'b1, 1'b0, 2'd0, 32'h104, 4'd4, 3'b001, TBL_U[k][0], TBL_U[k], "R7");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule